// File: doc/BRIEF.md
# Serial Audio Master Transmitter

This block drives a two-channel serial audio link as its clock master. It makes a bit clock by dividing the system clock, produces the left/right word-select line, and sends 32-bit sample words most significant bit first. Software or a DMA engine writes sample bytes into a 64-byte transmit queue; every four bytes, taken in big-endian order, form one word, and each half-frame carries one word.

The half-frame length in bit clocks is set apart from the word width. When it is longer than 32, the extra bit periods carry zeros. The first bit of each word leaves one bit period after the word-select line changes level. A level comparator on the queue's byte count tells the feeding side when to refill, and that alarm can be passed to an interrupt line or masked. If the queue lacks a whole word when one is due, the block sends a zero word and latches an underrun flag.

Configuration comes in on plain input ports and must stay steady while the transmitter is enabled. To change it, deassert the enable, update the values, then enable again.

Top module: `i2s_tx_master`

## Requirements
- R1: Words are sent most significant bit first. The first byte written to the queue for a word becomes bits 31:24 of that word, and the fourth becomes bits 7:0.
- R2: A half-frame lasts `cfg_slot_len` bit clocks. A value below 32 is treated as 32. Every bit period of a half-frame that carries no word bit drives `sdata` low.
- R3: Bit 31 of a word appears in bit period 1 of its half-frame, counting the period in which `lrck` changes as period 0. Bit 0 appears in period 32. When the half-frame length is exactly 32, that period is period 0 of the next half-frame.
- R4: While enabled, `lrck` and `sdata` change only in the system clock cycle in which `bclk` falls, so they are steady when `bclk` rises.
- R5: While enabled with `cfg_div` = N > 0, `bclk` has a period of 2·N system clocks at 50% duty. While disabled, `bclk` is high. While enabled with `cfg_div` = 0, `bclk` stays where it is, so it stays high when enabled straight from the disabled state.
- R6: While disabled, `lrck` is high and `sdata` is low. The first half-frame after enabling has `lrck` low, and its period 0 carries a zero.
- R7: When a word is due and the queue holds fewer than 4 bytes, an all-zero word is sent and `underrun` goes high. It stays high while enabled, and it is cleared by reset and by a new enable.
- R8: The queue holds 64 bytes. `fifo_full` is high at 64 bytes, and a write while full is dropped.
- R9: `tx_alarm` is high when the queue's byte count is less than or equal to `cfg_alarm_lvl`. `tx_irq` equals `tx_alarm` AND `cfg_irq_en`.
- R10: After reset the queue is empty, `bclk` and `lrck` are high, and `sdata` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Transmitter enable |
| cfg_div | input | 8 | Half bit-clock period in system clocks; 0 stops the clock |
| cfg_slot_len | input | 7 | Bit clocks per half-frame (minimum 32) |
| cfg_alarm_lvl | input | 7 | Alarm byte-count threshold |
| cfg_irq_en | input | 1 | Lets the alarm through to `tx_irq` |
| wr_valid | input | 1 | Write one byte into the queue |
| wr_byte | input | 8 | Byte to write |
| fifo_full | output | 1 | Queue holds 64 bytes |
| tx_alarm | output | 1 | Byte count at or below threshold |
| tx_irq | output | 1 | Masked alarm |
| underrun | output | 1 | Sticky: a zero word was sent for lack of data |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Word select, low for the first half-frame |
| sdata | output | 1 | Serial data |

## Verification
The bench follows the link at each rising bit-clock edge and compares every bit against a model built from the bytes it wrote. It sweeps random half-frame lengths, including exactly 32, where a late-by-one design would drop the LSB or repeat a bit, and values below 32, which would truncate words if the clamp were missing. It overfills the queue, so a design that accepts writes while full would shift later words off their expected bytes. It also starts the link with an empty queue and with a zero divider: a design that sent stale data, failed to latch the underrun, or let `bclk` run at divide zero would break the bit or level checks. Alarm thresholds are probed at the exact byte count, where an off-by-one comparator flips the alarm one byte early or late.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    parameter int BYTE_BITS  = 8;
    parameter int DATA_BITS  = 32;
    parameter int WORD_BYTES = DATA_BITS / BYTE_BITS;
    parameter int FIFO_BYTES = 64;
    parameter int PTR_W      = $clog2(FIFO_BYTES);
    parameter int LVL_W      = PTR_W + 1;
    parameter int DIV_W      = 8;
    parameter int LEN_W      = 7;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
    } fifo_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } clk_state_t;

    typedef struct packed {
        logic                 run;
        logic [LEN_W-1:0]     pos;
        logic                 lr;
        logic [DATA_BITS-1:0] sh;
        logic                 underrun;
    } slot_state_t;
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo
    import i2s_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [BYTE_BITS-1:0] push_data,
    input  logic                 pop,
    output logic [DATA_BITS-1:0] word_out,
    output logic                 has_word,
    output logic                 full,
    output logic [LVL_W-1:0]     level
);
    fifo_state_t st_d, st_q;
    logic [BYTE_BITS-1:0] mem [FIFO_BYTES];
    logic push_ok, pop_ok;

    // Big-endian assembly: oldest byte lands in the top byte lane.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign word_out[DATA_BITS-1-g*BYTE_BITS -: BYTE_BITS] = mem[st_q.rd_ptr + PTR_W'(g)];
    end

    assign full     = (st_q.level == LVL_W'(FIFO_BYTES));
    assign has_word = (st_q.level >= LVL_W'(WORD_BYTES));
    assign level    = st_q.level;

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full;
        pop_ok  = pop && has_word;
        if (push_ok) st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
        if (pop_ok)  st_d.rd_ptr = st_q.rd_ptr + PTR_W'(WORD_BYTES);
        st_d.level = st_q.level + LVL_W'(push_ok) - (pop_ok ? LVL_W'(WORD_BYTES) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= push_data;
    end

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LVL_W'(FIFO_BYTES));

    // R7
    pop_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> has_word);
endmodule

// File: rtl/tx_bclk_gen.sv
module tx_bclk_gen
    import i2s_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             fall_evt
);
    clk_state_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d     = st_q;
        fall_evt = 1'b0;
        tick     = (div != '0) && (st_q.cnt == div - DIV_W'(1));
        if (!en) begin
            st_d.cnt  = '0;
            st_d.bclk = 1'b1;
        end else if (div == '0) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
            fall_evt  = st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, bclk: 1'b1};
        else        st_q <= st_d;
    end

    assign bclk = st_q.bclk;

    // R5
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> bclk);
endmodule

// File: rtl/tx_slot_shifter.sv
module tx_slot_shifter
    import i2s_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 fall_evt,
    input  logic [LEN_W-1:0]     slot_len,
    input  logic [DATA_BITS-1:0] word,
    input  logic                 has_word,
    output logic                 pop,
    output logic                 lrck,
    output logic                 sdata,
    output logic                 underrun
);
    slot_state_t st_d, st_q;
    logic [LEN_W-1:0] last_pos, cur_pos, nxt_pos;
    logic             cur_lr;

    assign last_pos = (slot_len < LEN_W'(DATA_BITS)) ? LEN_W'(DATA_BITS - 1) : slot_len - LEN_W'(1);

    always_comb begin
        st_d    = st_q;
        pop     = 1'b0;
        cur_pos = st_q.run ? st_q.pos : last_pos;
        cur_lr  = st_q.run ? st_q.lr  : 1'b1;
        nxt_pos = (cur_pos == last_pos) ? '0 : cur_pos + LEN_W'(1);
        st_d.run = en;
        if (!en) begin
            st_d.pos = last_pos;
            st_d.lr  = 1'b1;
            st_d.sh  = '0;
        end else begin
            if (!st_q.run) begin
                st_d.underrun = 1'b0;
                st_d.pos      = cur_pos;
                st_d.lr       = cur_lr;
            end
            if (fall_evt) begin
                st_d.pos = nxt_pos;
                st_d.lr  = (cur_pos == last_pos) ? ~cur_lr : cur_lr;
                if (nxt_pos == LEN_W'(1)) begin
                    if (has_word) begin
                        pop     = 1'b1;
                        st_d.sh = word;
                    end else begin
                        st_d.sh       = '0;
                        st_d.underrun = 1'b1;
                    end
                end else begin
                    st_d.sh = {st_q.sh[DATA_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{run: 1'b0, pos: '0, lr: 1'b1, sh: '0, underrun: 1'b0};
        else        st_q <= st_d;
    end

    assign lrck     = st_q.lr;
    assign sdata    = st_q.sh[DATA_BITS-1];
    assign underrun = st_q.underrun;

    // R7
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) && $past(st_q.run) && $past(st_q.underrun) |-> st_q.underrun);

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && st_q.run |-> st_q.pos <= last_pos);
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
    import i2s_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_enable,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [LEN_W-1:0]     cfg_slot_len,
    input  logic [LVL_W-1:0]     cfg_alarm_lvl,
    input  logic                 cfg_irq_en,
    input  logic                 wr_valid,
    input  logic [BYTE_BITS-1:0] wr_byte,
    output logic                 fifo_full,
    output logic                 tx_alarm,
    output logic                 tx_irq,
    output logic                 underrun,
    output logic                 bclk,
    output logic                 lrck,
    output logic                 sdata
);
    logic [DATA_BITS-1:0] q_word;
    logic                 q_has_word, q_pop, fall_evt;
    logic [LVL_W-1:0]     q_level;

    tx_byte_fifo u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .push_data(wr_byte),
        .pop(q_pop), .word_out(q_word), .has_word(q_has_word),
        .full(fifo_full), .level(q_level)
    );

    tx_bclk_gen u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .div(cfg_div),
        .bclk(bclk), .fall_evt(fall_evt)
    );

    tx_slot_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .fall_evt(fall_evt),
        .slot_len(cfg_slot_len), .word(q_word), .has_word(q_has_word),
        .pop(q_pop), .lrck(lrck), .sdata(sdata), .underrun(underrun)
    );

    always_comb begin
        tx_alarm = (q_level <= cfg_alarm_lvl);
        tx_irq   = tx_alarm && cfg_irq_en;
    end

    // R4
    lrck_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && $past(cfg_enable) && (lrck != $past(lrck)) |-> $fell(bclk));

    // R4
    sdata_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable && $past(cfg_enable) && !$fell(bclk) |-> $stable(sdata));
endmodule

// File: tb/i2s_tx_master_bench.sv
module i2s_tx_master_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [7:0] cfg_div = 8'd1;
    logic [6:0] cfg_slot_len = 7'd40;
    logic [6:0] cfg_alarm_lvl = 7'd16;
    logic       cfg_irq_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'd0;
    logic       fifo_full, tx_alarm, tx_irq, underrun, bclk, lrck, sdata;

    int checks = 0;
    int failures = 0;
    int level_m = 0;
    logic [31:0] wq [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_tx_master u_i2s_tx_master (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_div(cfg_div),
        .cfg_slot_len(cfg_slot_len), .cfg_alarm_lvl(cfg_alarm_lvl),
        .cfg_irq_en(cfg_irq_en), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .fifo_full(fifo_full), .tx_alarm(tx_alarm), .tx_irq(tx_irq),
        .underrun(underrun), .bclk(bclk), .lrck(lrck), .sdata(sdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_byte  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        if (level_m < 64) level_m++;
    endtask

    task automatic put_word(input int idx, input logic [31:0] w);
        wq[idx] = w;
        for (int k = 3; k >= 0; k--) put_byte(w[k*8 +: 8]);
    endtask

    function automatic logic exp_bit(input int s, input int p, input int eff, input int n);
        if (p >= 1 && p <= 32 && s < n) return wq[s][32-p];
        if (p == 0 && eff == 32 && s >= 1 && s - 1 < n) return wq[s-1][0];
        return 1'b0;
    endfunction

    task automatic run_stream(input int div, input int len, input int n);
        int eff = (len < 32) ? 32 : len;
        int i = 0;
        int cyc = 0;
        int last_rise = -1;
        logic prev;
        cfg_div = 8'(div);
        cfg_slot_len = 7'(len);
        cfg_enable = 1'b1;
        prev = 1'b1;
        while (i <= n * eff + 1 && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            if (!prev && bclk) begin
                int s = i / eff;
                int p = i % eff;
                if (last_rise >= 0 && i < 4)
                    chk(cyc - last_rise == 2 * div, "R5", "bclk period", cyc - last_rise, 2 * div);
                last_rise = cyc;
                if (i <= n * eff) begin
                    // R1 R2 R3 R6 bit stream
                    chk(sdata == exp_bit(s, p, eff, n), "R1/R2/R3", "sdata bit", sdata, exp_bit(s, p, eff, n));
                    chk(lrck == 1'(s % 2), "R6", "lrck level", lrck, s % 2);
                    if (i == n * eff) chk(underrun == 1'b0, "R7", "underrun early", underrun, 0);
                end else begin
                    chk(underrun == 1'b1, "R7", "underrun set", underrun, 1);
                    chk(sdata == 1'b0, "R7", "zero word", sdata, 0);
                end
                i++;
            end
            prev = bclk;
        end
        chk(i > n * eff + 1, "R5", "stream completed", i, n * eff + 2);
        cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(bclk && lrck && !sdata, "R6", "idle levels", {bclk, lrck, sdata}, 3'b110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1..R10 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(bclk == 1'b1, "R10", "bclk reset", bclk, 1);
        chk(lrck == 1'b1, "R10", "lrck reset", lrck, 1);
        chk(sdata == 1'b0, "R10", "sdata reset", sdata, 0);
        chk(underrun == 1'b0, "R10", "underrun reset", underrun, 0);
        chk(fifo_full == 1'b0, "R10", "fifo empty", fifo_full, 0);
        chk(tx_alarm == 1'b1, "R9", "alarm empty", tx_alarm, 1);
        chk(tx_irq == 1'b0, "R9", "irq masked", tx_irq, 0);
        cfg_irq_en = 1'b1;
        @(negedge clk);
        chk(tx_irq == 1'b1, "R9", "irq enabled", tx_irq, 1);

        // R9 threshold edge and R8 overfill
        for (int w = 0; w < 16; w++) begin
            put_word(w, $urandom);
            if (w == 3) chk(tx_alarm == 1'b1, "R9", "alarm at 16", tx_alarm, 1);
        end
        chk(tx_alarm == 1'b0, "R9", "alarm above", tx_alarm, 0);
        chk(fifo_full == 1'b1, "R8", "full at 64", fifo_full, 1);
        for (int k = 0; k < 6; k++) put_byte(8'($urandom));
        chk(fifo_full == 1'b1, "R8", "still full", fifo_full, 1);
        level_m = 64;
        run_stream(2, 40, 16);

        // R7 empty start, then clear on new enable
        run_stream(1, 40, 0);
        cfg_enable = 1'b1;
        @(negedge clk);
        chk(underrun == 1'b0, "R7", "cleared by enable", underrun, 0);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);

        // R5 divide zero holds bclk
        cfg_div = 8'd0;
        cfg_enable = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k % 10 == 9) chk(bclk == 1'b1 && lrck == 1'b1, "R5", "div0 stopped", {bclk, lrck}, 2'b11);
        end
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);

        // Random configurations with directed lengths 32 and below 32 (R2 R3)
        for (int t = 0; t < 8; t++) begin
            int len;
            int n;
            case (t)
                0: len = 32;
                1: len = 20;
                2: len = 33;
                default: len = 32 + int'($urandom % 19);
            endcase
            n = 2 + int'($urandom % 15);
            level_m = 0;
            cfg_alarm_lvl = 7'($urandom % 64);
            for (int w = 0; w < n; w++) put_word(w, $urandom);
            chk(tx_alarm == (level_m <= int'(cfg_alarm_lvl)), "R9", "alarm compare", tx_alarm, level_m <= int'(cfg_alarm_lvl));
            run_stream(1 + int'($urandom % 3), len, n);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule